// File: doc/BRIEF.md
# Clock Alarm and Interrupt Flag Unit

This unit gathers three kinds of timekeeping event into one flag register and one shared interrupt request. The three events are a programmable periodic tick, a clock alarm and a power-fail notice. The periodic source divides a 32768 Hz tick enable down to one of fifteen rates. There are two kinds of rate. The binary rates are power-of-two divisions of the tick. The 10 ms and 100 ms rates come from a fractional decimal divider. The alarm source runs on each once-per-second update strobe. It compares the current seconds, minutes, hours and date with four alarm registers. Bit 7 of each alarm register masks its field out of the compare.

Each event sets its own flag. A flag drives the interrupt request only when its enable bit is set. The flags are cleared on the clock edge that ends a flags read. During battery backup the request is held released, with one exception: it may still be driven by an alarm when the alarm-in-backup enable is set. The `irq_pull_o` output stands for an open-drain pull-down. When it is 1 the shared line is pulled low. All ports are plain control and status pins. There is no streaming interface, so no valid/ready or back-pressure rules apply.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, all flags are 0, all enables are 0 and `irq_pull_o` is 0. An alarm event that arrives before any enable is written therefore sets only its flag.
- R2: The control register is written with `reg_addr_i`=4. Its bits [7:4] hold the rate code and bit 0 holds the periodic enable. Any write to it restarts the periodic dividers. For a rate code c from 3 to 15, the periodic flag (flags bit 0) is set on exactly the 2^(c-1)-th tick after the write.
- R3: Rate code 1 sets the periodic flag on the 328th tick after a control write, which is 10 ms on average. Rate code 2 sets it on the 3277th tick, which is 100 ms. Rate code 0 never sets it.
- R4: Alarm registers are written at addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (date). Bit 7 of each register masks that field and bits [6:0] are compared. On an update strobe, the alarm flag (flags bit 1) is set when every unmasked field equals the current value. With all four masks set, every strobe sets the flag. Without a strobe, nothing is set.
- R5: A power-fail event pulse sets the power-fail flag (flags bit 2).
- R6: `irq_pull_o` is 1 when any flag is set together with its enable. The enables are control bit 0 (periodic), bit 1 (alarm) and bit 2 (power fail). A flag whose enable is clear leaves `irq_pull_o` at 0.
- R7: During a flags read, `flags_o` still shows the set flags. On the edge that ends the read, all flags clear and the request is released.
- R8: An event that arrives in the same cycle as a flags read leaves its flag set after the read.
- R9: While `backup_i` is 1, `irq_pull_o` is 1 only when three things hold: the alarm flag is set, the alarm enable is set, and the alarm-in-backup enable (control bit 3) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tick_i | input | 1 | 32768 Hz tick enable |
| sec_pulse_i | input | 1 | Once-per-second update strobe |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_date_i | input | 8 | Current date, BCD |
| pwr_fail_i | input | 1 | Power-fail event pulse |
| backup_i | input | 1 | Battery-backup mode indicator |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| flags_rd_i | input | 1 | Flags read; its last cycle ends the access |
| flags_o | output | 3 | Flags: bit 0 periodic, bit 1 alarm, bit 2 power fail |
| irq_pull_o | output | 1 | 1 pulls the shared interrupt line low |

## Verification
A wrong divider state shows up as the periodic flag rising one or more ticks early or late. The bench counts ticks from a control write to the exact tick, so an off-by-one shows up at once. This holds even for the longest rate, 16384 ticks. A bad mask or compare shows on the first update strobe that either should or should not set the alarm flag. A fault in the clear logic or in the enable gating shows on `flags_o` or `irq_pull_o` one cycle after the read or the event.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NFLAG    = 3;
  localparam int FLAG_PER = 0;
  localparam int FLAG_ALM = 1;
  localparam int FLAG_PWR = 2;

  typedef enum logic [2:0] {
    RA_ALM_SEC  = 3'd0,
    RA_ALM_MIN  = 3'd1,
    RA_ALM_HOUR = 3'd2,
    RA_ALM_DATE = 3'd3,
    RA_CTRL     = 3'd4
  } reg_addr_e;

  // control byte: [7:4] rate code, [3] alarm in backup, [2] power-fail en,
  // [1] alarm en, [0] periodic en
  typedef struct packed {
    logic [3:0] rate;
    logic       abe;
    logic       pwr_en;
    logic       alm_en;
    logic       per_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int RATE_W   = 4,
  parameter int CNT_W    = 14,
  parameter int DEC_STEP = 25,
  parameter int DEC_MOD  = 8192,
  parameter int DECADE   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              evt_o
);
  localparam int DEC_W = $clog2(DEC_MOD) + 1;
  localparam int D10_W = $clog2(DECADE);

  logic [CNT_W-1:0] bin_cnt;
  logic [CNT_W-1:0] bin_mask;
  logic [DEC_W-1:0] dec_acc;
  logic [DEC_W-1:0] dec_sum;
  logic [D10_W-1:0] dec10;
  logic             dec_hit, dec100_hit, bin_hit;

  always_comb begin
    if (rate_i >= RATE_W'(3))
      bin_mask = CNT_W'((32'd1 << (32'(rate_i) - 32'd1)) - 32'd1);
    else
      bin_mask = '0;
    dec_sum    = dec_acc + DEC_W'(DEC_STEP);
    dec_hit    = tick_i && (dec_sum >= DEC_W'(DEC_MOD));
    dec100_hit = dec_hit && (dec10 == D10_W'(DECADE - 1));
    bin_hit    = tick_i && (rate_i >= RATE_W'(3)) && ((bin_cnt & bin_mask) == bin_mask);
    case (rate_i)
      RATE_W'(0): evt_o = 1'b0;
      RATE_W'(1): evt_o = dec_hit;
      RATE_W'(2): evt_o = dec100_hit;
      default:    evt_o = bin_hit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_cnt <= '0;
      dec_acc <= '0;
      dec10   <= '0;
    end else if (restart_i) begin
      bin_cnt <= '0;
      dec_acc <= '0;
      dec10   <= '0;
    end else if (tick_i) begin
      bin_cnt <= bin_cnt + 1'b1;
      dec_acc <= dec_hit ? dec_sum - DEC_W'(DEC_MOD) : dec_sum;
      if (dec_hit)
        dec10 <= (dec10 == D10_W'(DECADE - 1)) ? '0 : dec10 + 1'b1;
    end
  end

  a_r2_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !evt_o);
  a_r3_code_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |-> !evt_o);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NFIELD = 4,
  parameter int FW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_pulse_i,
  input  logic [NFIELD-1:0][FW-1:0]  cur_i,
  input  logic [NFIELD-1:0][FW-1:0]  alm_i,
  output logic                       evt_o
);
  logic [NFIELD-1:0] field_ok;
  logic [NFIELD-1:0] mask_all;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign mask_all[i] = alm_i[i][FW-1];
    assign field_ok[i] = alm_i[i][FW-1] | (alm_i[i][FW-2:0] == cur_i[i][FW-2:0]);
  end

  assign evt_o = sec_pulse_i & (&field_ok);

  a_r4_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse_i && (&mask_all)) |-> evt_o);
  a_r4_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse_i |-> !evt_o);
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i)    flags_o[i] <= 1'b0;
    end
  end

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags_o == '0));
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int DEC_STEP = 25,
  parameter int DEC_MOD  = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sec_pulse_i,
  input  logic [7:0]       cur_sec_i,
  input  logic [7:0]       cur_min_i,
  input  logic [7:0]       cur_hour_i,
  input  logic [7:0]       cur_date_i,
  input  logic             pwr_fail_i,
  input  logic             backup_i,
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             flags_rd_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_pull_o
);
  localparam int NFIELD = 4;

  ctrl_t                  ctrl_q;
  logic [NFIELD-1:0][7:0] alm_q;
  logic [NFIELD-1:0][7:0] cur_vec;
  logic                   ctrl_wr;
  logic                   per_evt, alm_evt;
  logic [NFLAG-1:0]       evt;
  logic [NFLAG-1:0]       en_vec;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign cur_vec = {cur_date_i, cur_hour_i, cur_min_i, cur_sec_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i);
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q[i] <= '0;
      else if (reg_wr_i && (reg_addr_i == 3'(i))) alm_q[i] <= reg_wdata_i;
    end
  end

  rtc_periodic_gen #(
    .RATE_W(4), .CNT_W(CNT_W), .DEC_STEP(DEC_STEP), .DEC_MOD(DEC_MOD), .DECADE(10)
  ) u_per (
    .clk(clk), .rst_n(rst_n), .restart_i(ctrl_wr), .tick_i(tick_i),
    .rate_i(ctrl_q.rate), .evt_o(per_evt)
  );

  rtc_alarm_match #(.NFIELD(NFIELD), .FW(8)) u_alm (
    .clk(clk), .rst_n(rst_n), .sec_pulse_i(sec_pulse_i),
    .cur_i(cur_vec), .alm_i(alm_q), .evt_o(alm_evt)
  );

  always_comb begin
    evt           = '0;
    evt[FLAG_PER] = per_evt;
    evt[FLAG_ALM] = alm_evt;
    evt[FLAG_PWR] = pwr_fail_i;
    en_vec           = '0;
    en_vec[FLAG_PER] = ctrl_q.per_en;
    en_vec[FLAG_ALM] = ctrl_q.alm_en;
    en_vec[FLAG_PWR] = ctrl_q.pwr_en;
  end

  rtc_flag_reg #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(flags_rd_i), .flags_o(flags_o)
  );

  always_comb begin
    if (backup_i)
      irq_pull_o = ctrl_q.abe & ctrl_q.alm_en & flags_o[FLAG_ALM];
    else
      irq_pull_o = |(flags_o & en_vec);
  end

  a_r6_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o == '0) |-> !irq_pull_o);
  a_r9_backup_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (backup_i && !flags_o[FLAG_ALM]) |-> !irq_pull_o);
  a_r5_pwr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> flags_o[FLAG_PWR]);
endmodule

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, sec_pulse_i = 1'b0, pwr_fail_i = 1'b0, backup_i = 1'b0;
  logic [7:0] cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0, cur_date_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       flags_rd_i = 1'b0;
  logic [2:0] flags_o;
  logic       irq_pull_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rtc_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sec_pulse_i(sec_pulse_i),
    .cur_sec_i(cur_sec_i), .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
    .cur_date_i(cur_date_i), .pwr_fail_i(pwr_fail_i), .backup_i(backup_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .flags_rd_i(flags_rd_i), .flags_o(flags_o), .irq_pull_o(irq_pull_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(output logic [2:0] v);
    v = flags_o;
    flags_rd_i = 1'b1;
    @(negedge clk);
    flags_rd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic second(input logic [7:0] d, h, m, s);
    cur_date_i = d; cur_hour_i = h; cur_min_i = m; cur_sec_i = s;
    sec_pulse_i = 1'b1;
    @(negedge clk);
    sec_pulse_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [2:0] v;
    chk("R1 flags after reset", flags_o, 0);
    chk("R1 irq after reset", irq_pull_o, 0);
    second(8'h00, 8'h00, 8'h00, 8'h00);
    chk("R1 alarm flag set with zero enables", flags_o, 3'b010);
    chk("R1 irq idle with enables cleared", irq_pull_o, 0);
    rd(v);
  endtask

  task automatic t_binary(input int code);
    logic [2:0] v;
    int n;
    n = 1 << (code - 1);
    wr(3'd4, 8'(code << 4));
    rd(v);
    wr(3'd4, 8'(code << 4));
    ticks(n - 1);
    chk($sformatf("R2 code %0d before period", code), flags_o[0], 0);
    ticks(1);
    chk($sformatf("R2 code %0d at period", code), flags_o[0], 1);
    chk("R6 periodic without enable no irq", irq_pull_o, 0);
    rd(v);
  endtask

  task automatic t_decimal;
    logic [2:0] v;
    wr(3'd4, 8'h10);
    rd(v);
    wr(3'd4, 8'h10);
    ticks(327);
    chk("R3 10ms before tick 328", flags_o[0], 0);
    ticks(1);
    chk("R3 10ms at tick 328", flags_o[0], 1);
    wr(3'd4, 8'h20);
    rd(v);
    wr(3'd4, 8'h20);
    ticks(3276);
    chk("R3 100ms before tick 3277", flags_o[0], 0);
    ticks(1);
    chk("R3 100ms at tick 3277", flags_o[0], 1);
    wr(3'd4, 8'h00);
    rd(v);
    ticks(20000);
    chk("R3 code 0 never sets periodic", flags_o[0], 0);
  endtask

  task automatic t_read_clear;
    logic [2:0] v;
    wr(3'd4, 8'h31);
    ticks(4);
    chk("R6 periodic with enable drives irq", irq_pull_o, 1);
    rd(v);
    chk("R7 read returns set flag", v[0], 1);
    chk("R7 flags cleared after read", flags_o, 0);
    chk("R7 irq released after read", irq_pull_o, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_alarm;
    logic [2:0] v;
    rd(v);
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h92); wr(3'd3, 8'h85);
    second(8'h07, 8'h03, 8'h15, 8'h30);
    chk("R4 min+sec match sets alarm", flags_o[1], 1);
    rd(v);
    second(8'h07, 8'h03, 8'h15, 8'h31);
    chk("R4 seconds mismatch no alarm", flags_o[1], 0);
    cur_sec_i = 8'h30; @(negedge clk);
    chk("R4 match without strobe no alarm", flags_o[1], 0);
    wr(3'd2, 8'h12); wr(3'd3, 8'h05);
    second(8'h06, 8'h12, 8'h15, 8'h30);
    chk("R4 full compare date mismatch", flags_o[1], 0);
    second(8'h05, 8'h12, 8'h15, 8'h30);
    chk("R4 full compare all match", flags_o[1], 1);
    rd(v);
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    second(8'h19, 8'h22, 8'h47, 8'h03);
    chk("R4 all masks fire every second", flags_o[1], 1);
    rd(v);
  endtask

  task automatic t_pwr;
    logic [2:0] v;
    pwr_fail_i = 1'b1; @(negedge clk); pwr_fail_i = 1'b0;
    chk("R5 power fail flag set", flags_o, 3'b100);
    chk("R6 power fail without enable no irq", irq_pull_o, 0);
    wr(3'd4, 8'h04);
    chk("R6 power fail with enable irq", irq_pull_o, 1);
    rd(v);
    pwr_fail_i = 1'b1; flags_rd_i = 1'b1;
    @(negedge clk);
    pwr_fail_i = 1'b0; flags_rd_i = 1'b0;
    chk("R8 event during read kept", flags_o[2], 1);
    rd(v);
  endtask

  task automatic t_backup;
    logic [2:0] v;
    wr(3'd4, 8'h0E);
    pwr_fail_i = 1'b1; @(negedge clk); pwr_fail_i = 1'b0;
    backup_i = 1'b1; @(negedge clk);
    chk("R9 backup power flag no irq", irq_pull_o, 0);
    second(8'h01, 8'h01, 8'h01, 8'h01);
    chk("R9 backup alarm with abe irq", irq_pull_o, 1);
    wr(3'd4, 8'h06);
    chk("R9 backup alarm without abe no irq", irq_pull_o, 0);
    backup_i = 1'b0; @(negedge clk);
    chk("R6 leaving backup restores irq", irq_pull_o, 1);
    rd(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_binary(3);
    t_binary(8);
    t_binary(15);
    t_decimal();
    t_read_clear();
    t_alarm();
    t_pwr();
    t_backup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired before the run completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule